// File: doc/BRIEF.md
# Instruction Byte Usage Gating Store

This block sits between an instruction fill path and a small instruction store. Each 32-bit instruction is kept as four separate 8-bit lanes. On a fill it works out one enable flag per lane. The two upper lanes hold the opcode and register fields. Each of them is enabled only when its contents are nonzero. The two lower lanes are enabled according to the length class that arrives with the instruction. A short instruction uses neither lower lane. A medium instruction uses lane 1. A long instruction uses lanes 1 and 0.

A disabled lane is neither written on fill nor read on fetch. The flags are stored beside the data. A fetch reads the flags first and uses them to gate the per-lane reads. A lane whose flag is clear comes back as zero, so the fetched word equals the filled word with its unused lanes cleared.

Fetch data, the stored flags and a count of suppressed lanes all appear one cycle after the request. The fill side also reports, in the same cycle, the flags it will store and how many lanes it skips. These counts make the saving in storage activity visible in simulation.

Top module: `ibyte_gate_store`

## Requirements
- R1: On a fill, wr_flags[3] is 1 exactly when wr_instr[31:24] is nonzero, and wr_flags[2] is 1 exactly when wr_instr[23:16] is nonzero. These flags appear combinationally in the fill cycle.
- R2: wr_flags[1:0] follow the length class wr_len: 2'b00 gives 2'b00, 2'b01 gives 2'b10, and 2'b10 or 2'b11 gives 2'b11. The lower lanes get no zero detection.
- R3: A lane filled with its flag clear reads back as zero, even when an earlier fill left nonzero data in that lane at the same address.
- R4: rd_en in one cycle makes rd_valid 1 in the next cycle. In that cycle rd_flags holds the flags stored at rd_addr, and rd_instr holds the stored word with every lane whose flag is clear forced to zero (lane k is bits 8k+7:8k).
- R5: In a cycle that follows a cycle without rd_en, rd_valid, rd_instr, rd_flags and rd_gated_cnt are all zero.
- R6: wr_gated_cnt equals the number of clear bits in wr_flags. rd_gated_cnt equals the number of clear bits in rd_flags whenever rd_valid is 1.
- R7: After reset, rd_valid is 0, and every address reads back rd_instr 0, rd_flags 0 and rd_gated_cnt 4.
- R8: A fetch from the address being filled in the same cycle returns the contents from before that fill.
- R9: wr_flags[3:2] do not depend on wr_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Fill request |
| wr_addr | input | ADDR_W (4) | Fill address |
| wr_instr | input | 32 | Instruction word to fill |
| wr_len | input | 2 | Length class: 00 short, 01 medium, 10/11 long |
| wr_flags | output | 4 | Lane enables computed for the current fill |
| wr_gated_cnt | output | 3 | Lanes skipped by the current fill |
| rd_en | input | 1 | Fetch request |
| rd_addr | input | ADDR_W (4) | Fetch address |
| rd_valid | output | 1 | Fetch result present (one cycle after rd_en) |
| rd_instr | output | 32 | Fetched word, disabled lanes zero |
| rd_flags | output | 4 | Stored lane enables of the fetched entry |
| rd_gated_cnt | output | 3 | Lanes whose read was suppressed |

## Verification
The properties assume that wr_len and wr_instr are known whenever wr_en is high. They also assume rd_en is never unknown after reset. The bench drives every input to a defined value on each cycle, including idle ones, and it never leaves a request line floating. Addresses stay within the parameter depth because they are drawn from the address width. Same-address fill and fetch in one cycle is a legal pattern and is exercised on purpose.

// File: rtl/ibg_pkg.sv
package ibg_pkg;

    // The 8-8-8-8 split is fixed by behaviour: lanes 3..2 are zero-detected,
    // lanes 1..0 are usage-detected from the length class.
    localparam int unsigned LANES     = 4;
    localparam int unsigned UPPER_LO  = 2;
    localparam int unsigned CNT_W     = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        LEN_SHORT  = 2'b00,
        LEN_MEDIUM = 2'b01,
        LEN_LONG   = 2'b10,
        LEN_LONG_X = 2'b11
    } len_class_e;

    typedef logic [LANES-1:0] lane_mask_t;

    function automatic logic [CNT_W-1:0] count_clear(input lane_mask_t m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            if (!m[i]) n = n + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/ibg_len_usage.sv
module ibg_len_usage
    import ibg_pkg::*;
(
    input  logic [1:0] len_class,
    output logic [1:0] low_use
);

    len_class_e cls;

    always_comb begin
        cls = len_class_e'(len_class);
        unique case (cls)
            LEN_SHORT:  low_use = 2'b00;
            LEN_MEDIUM: low_use = 2'b10;
            LEN_LONG:   low_use = 2'b11;
            LEN_LONG_X: low_use = 2'b11;
            default:    low_use = 2'b11;
        endcase
    end

endmodule

// File: rtl/ibg_flag_encoder.sv
module ibg_flag_encoder
    import ibg_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [1:0]        len_class,
    output lane_mask_t        flags,
    output logic [CNT_W-1:0]  gated_cnt
);

    logic [1:0] low_use;

    ibg_len_usage u_len (
        .len_class (len_class),
        .low_use   (low_use)
    );

    for (genvar g = UPPER_LO; g < LANES; g++) begin : g_upper
        assign flags[g] = |instr[g*LANE_W +: LANE_W];
    end

    for (genvar g = 0; g < UPPER_LO; g++) begin : g_lower
        assign flags[g] = low_use[g];
    end

    assign gated_cnt = count_clear(flags);

endmodule

// File: rtl/ibg_lane_bank.sv
module ibg_lane_bank #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][LANE_W-1:0] mem;
        logic [LANE_W-1:0]            dout;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Read uses the contents present before this cycle's write.
        st_d.dout = rd_en ? st_q.mem[rd_addr] : '0;
        if (wr_en) begin
            st_d.mem[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.dout;

endmodule

// File: rtl/ibg_flag_store.sv
module ibg_flag_store
    import ibg_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  lane_mask_t        wr_flags,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output lane_mask_t        lane_rd_en,
    output logic              rd_valid,
    output lane_mask_t        rd_flags,
    output logic [CNT_W-1:0]  rd_gated_cnt
);

    typedef struct packed {
        logic [DEPTH-1:0][LANES-1:0] mem;
        logic                        valid;
        lane_mask_t                  flags;
        logic [CNT_W-1:0]            cnt;
    } fstore_st_t;

    fstore_st_t st_d, st_q;
    lane_mask_t cur_flags;

    // Flags are looked up first; they gate the per-lane data reads.
    assign cur_flags  = st_q.mem[rd_addr];
    assign lane_rd_en = rd_en ? cur_flags : '0;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en;
        st_d.flags = rd_en ? cur_flags : '0;
        st_d.cnt   = rd_en ? count_clear(cur_flags) : '0;
        if (wr_en) begin
            st_d.mem[wr_addr] = wr_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid     = st_q.valid;
    assign rd_flags     = st_q.flags;
    assign rd_gated_cnt = st_q.cnt;

endmodule

// File: rtl/ibyte_gate_store.sv
module ibyte_gate_store
    import ibg_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_instr,
    input  logic [1:0]        wr_len,
    output logic [LANES-1:0]  wr_flags,
    output logic [CNT_W-1:0]  wr_gated_cnt,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_instr,
    output logic [LANES-1:0]  rd_flags,
    output logic [CNT_W-1:0]  rd_gated_cnt
);

    lane_mask_t enc_flags;
    lane_mask_t lane_rd_en;
    lane_mask_t lane_wr_en;

    ibg_flag_encoder #(.LANE_W(LANE_W)) u_enc (
        .instr     (wr_instr),
        .len_class (wr_len),
        .flags     (enc_flags),
        .gated_cnt (wr_gated_cnt)
    );

    assign wr_flags   = enc_flags;
    assign lane_wr_en = wr_en ? enc_flags : '0;

    ibg_flag_store #(.DEPTH(DEPTH)) u_fst (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_flags     (enc_flags),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .lane_rd_en   (lane_rd_en),
        .rd_valid     (rd_valid),
        .rd_flags     (rd_flags),
        .rd_gated_cnt (rd_gated_cnt)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ibg_lane_bank #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (lane_wr_en[g]),
            .wr_addr (wr_addr),
            .wr_data (wr_instr[g*LANE_W +: LANE_W]),
            .rd_en   (lane_rd_en[g]),
            .rd_addr (rd_addr),
            .rd_data (rd_instr[g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/ibg_checker.sv
module ibg_checker #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [4*LANE_W-1:0] wr_instr,
    input logic [1:0]          wr_len,
    input logic [3:0]          wr_flags,
    input logic [2:0]          wr_gated_cnt,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic                rd_valid,
    input logic [4*LANE_W-1:0] rd_instr,
    input logic [3:0]          rd_flags,
    input logic [2:0]          rd_gated_cnt
);

    // R1: an all-zero upper lane is never enabled
    a_r1_zero_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_instr[4*LANE_W-1 -: LANE_W] == '0) |-> !wr_flags[3]);

    // R2: short class enables no lower lane
    a_r2_short_no_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_len == 2'b00) |-> wr_flags[1:0] == 2'b00);

    // R2: lane 0 is only used when lane 1 is used
    a_r2_low_nested: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags[0] |-> wr_flags[1]);

    // R4: one-cycle fetch latency
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R4: a disabled lane comes back as zero
    a_r4_gated_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_instr & ~{{LANE_W{rd_flags[3]}}, {LANE_W{rd_flags[2]}},
                                    {LANE_W{rd_flags[1]}}, {LANE_W{rd_flags[0]}}}) == '0));

    // R5: idle outputs are zero
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_instr == '0 && rd_flags == '0 && rd_gated_cnt == '0));

    // R6: fetch count matches the cleared flags
    a_r6_rd_count: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (32'(rd_gated_cnt) + $countones(rd_flags) == 4));

    // R6: fill count matches the cleared flags
    a_r6_wr_count: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_gated_cnt) + $countones(wr_flags) == 4));

endmodule

bind ibyte_gate_store ibg_checker #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_instr     (wr_instr),
    .wr_len       (wr_len),
    .wr_flags     (wr_flags),
    .wr_gated_cnt (wr_gated_cnt),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_valid     (rd_valid),
    .rd_instr     (rd_instr),
    .rd_flags     (rd_flags),
    .rd_gated_cnt (rd_gated_cnt)
);

// File: tb/sim_ibyte_gate_store.sv
`timescale 1ns/1ps
module sim_ibyte_gate_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_instr = '0;
    logic [1:0]  wr_len = '0;
    logic [3:0]  wr_flags;
    logic [2:0]  wr_gated_cnt;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_instr;
    logic [3:0]  rd_flags;
    logic [2:0]  rd_gated_cnt;

    always #2 clk = ~clk;

    ibyte_gate_store u0 (.*);

    typedef struct {
        logic        valid;
        logic [31:0] instr;
        logic [3:0]  flags;
        logic [2:0]  cnt;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] m_instr [16];
    logic [3:0]  m_flags [16];
    int          checks = 0;
    int          failures = 0;
    string       rd_tag = "R4";

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_flags(input logic [31:0] i, input logic [1:0] l);
        return {|i[31:24], |i[23:16], l != 2'b00, l[1]};
    endfunction

    function automatic logic [31:0] ref_mask(input logic [31:0] i, input logic [3:0] f);
        return i & {{8{f[3]}}, {8{f[2]}}, {8{f[1]}}, {8{f[0]}}};
    endfunction

    function automatic logic [2:0] ref_cnt(input logic [3:0] f);
        return 3'(4 - $countones(f));
    endfunction

    // One bus cycle: drive at the falling edge, queue the expected fetch result.
    task automatic step(input bit we, input logic [3:0] wa, input logic [31:0] wi,
                        input logic [1:0] wl, input bit re, input logic [3:0] ra);
        exp_t e;
        logic [3:0] ef;
        wr_en = we; wr_addr = wa; wr_instr = wi; wr_len = wl;
        rd_en = re; rd_addr = ra;
        #0.5;
        if (we) begin
            ef = ref_flags(wi, wl);
            chk(wr_flags[3:2] == ef[3:2], "R1", {28'd0, wr_flags}, {28'd0, ef});
            chk(wr_flags[1:0] == ef[1:0], "R2", {28'd0, wr_flags}, {28'd0, ef});
            chk(wr_gated_cnt == ref_cnt(ef), "R6", {29'd0, wr_gated_cnt},
                {29'd0, ref_cnt(ef)});
        end
        e.valid = re;
        e.instr = re ? m_instr[ra] : '0;
        e.flags = re ? m_flags[ra] : '0;
        e.cnt   = re ? ref_cnt(m_flags[ra]) : '0;
        e.tag   = re ? rd_tag : "R5";
        sb_q.push_back(e);
        @(posedge clk);
        if (we) begin
            ef = ref_flags(wi, wl);
            m_flags[wa] = ef;
            m_instr[wa] = ref_mask(wi, ef);
        end
        @(negedge clk);
    endtask

    // Monitor: compare each cycle's fetch outputs just after the edge.
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            #1;
            chk(rd_valid == e.valid, e.tag, {31'd0, rd_valid}, {31'd0, e.valid});
            chk(rd_instr == e.instr, e.tag, rd_instr, e.instr);
            chk(rd_flags == e.flags, e.tag, {28'd0, rd_flags}, {28'd0, e.flags});
            chk(rd_gated_cnt == e.cnt, (e.valid ? "R6" : e.tag),
                {29'd0, rd_gated_cnt}, {29'd0, e.cnt});
        end
    end

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_instr[i] = '0;
            m_flags[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state at the ports
        chk(rd_valid == 1'b0, "R7", {31'd0, rd_valid}, 32'd0);
        chk(rd_instr == '0, "R7", rd_instr, 32'd0);

        // R7: every entry reads back empty
        rd_tag = "R7";
        for (int a = 0; a < 16; a++) step(0, '0, '0, 2'b00, 1, 4'(a));
        rd_tag = "R4";

        // R1 R2 R4: distinct classes and zero patterns
        step(1, 4'd1, 32'h1234_5678, 2'b10, 0, '0);
        step(1, 4'd2, 32'h00AB_CDEF, 2'b00, 1, 4'd1);
        step(1, 4'd3, 32'hFF00_1234, 2'b01, 1, 4'd2);
        step(1, 4'd4, 32'h0102_0304, 2'b11, 1, 4'd3);
        step(1, 4'd6, 32'h0000_00FF, 2'b01, 1, 4'd4);
        step(0, '0, '0, 2'b00, 1, 4'd6);

        // R9: same upper bytes, each length class
        for (int l = 0; l < 4; l++) begin
            step(1, 4'd7, 32'h0080_5A5A, 2'(l), 0, '0);
            chk(wr_flags[3:2] == 2'b01, "R9", {28'd0, wr_flags}, 32'h4);
            step(0, '0, '0, 2'b00, 1, 4'd7);
        end

        // R3: stale lane data never shows once its flag is cleared
        step(1, 4'd1, 32'hDEAD_BEEF, 2'b10, 0, '0);
        step(1, 4'd1, 32'h0000_0000, 2'b00, 0, '0);
        rd_tag = "R3";
        step(0, '0, '0, 2'b00, 1, 4'd1);
        step(1, 4'd1, 32'hAA00_9999, 2'b01, 0, '0);
        step(0, '0, '0, 2'b00, 1, 4'd1);

        // R8: fetch and fill of one address in the same cycle
        rd_tag = "R8";
        step(1, 4'd5, 32'h1111_2222, 2'b10, 0, '0);
        step(1, 4'd5, 32'h3300_4455, 2'b01, 1, 4'd5);
        step(0, '0, '0, 2'b00, 1, 4'd5);
        rd_tag = "R4";

        // R5: idle cycles after traffic
        step(0, '0, '0, 2'b00, 0, '0);
        step(1, 4'd9, 32'h7777_7777, 2'b10, 0, '0);

        // Mixed traffic with bytes often zero
        for (int n = 0; n < 400; n++) begin
            logic [31:0] v;
            v = $urandom;
            for (int b = 0; b < 4; b++) if ($urandom % 2 == 0) v[b*8 +: 8] = 8'h00;
            step(($urandom % 3) != 0, 4'($urandom), v, 2'($urandom),
                 ($urandom % 3) != 0, 4'($urandom));
        end

        step(0, '0, '0, 2'b00, 0, '0);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule